// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns one parallel character per request into an asynchronous serial frame on a single transmit line that rests high. Each frame has a low start bit, then 5 to 9 data bits sent least significant first, an optional even or odd parity bit, and one or two high stop bits. The character length, parity mode and stop count come from static configuration inputs shared with a matching receiver.

Bit timing comes from an external divider that pulses `tick` for one clock cycle per bit interval. A word is taken through a valid/ready handshake. `in_ready` is raised only in a tick cycle, and only while the line is idle or while the last stop bit is ending. A frame therefore always starts on a bit boundary, and a pending word follows the previous frame with no idle gap. The data word and the configuration are both captured at acceptance.

Top module: `txf_serial_tx`

## Requirements
- R1: A word is accepted at a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in a cycle with `tick` high, and only when no frame is in progress or the last bit of the current frame is ending in that cycle. The start bit (low) is driven from the cycle after acceptance.
- R2: After the start bit, data bits `in_data[0]` up to `in_data[L-1]` are sent in that order, where L is the effective character length.
- R3: The effective length L is `cfg_len` when it lies in 5..9. Values below 5 are treated as 5, and values above 9 are treated as 9.
- R4: `cfg_parity` encoding: 2'b00 means no parity, 2'b01 is reserved and also means no parity, 2'b10 means even parity, and 2'b11 means odd parity. When parity is enabled, exactly one parity bit follows the last data bit.
- R5: The even parity bit is the XOR of data bits 0..L-1, and the odd parity bit is its inverse. Bits of `in_data` at or above L have no effect on the line.
- R6: The frame ends with stop bits driven high: one when `cfg_two_stop` is 0, two when it is 1.
- R7: Each bit is held for exactly one tick interval. The line changes only at the clock edge that ends a cycle with `tick` high.
- R8: If a word is valid when the last stop bit ends, its start bit follows that stop bit with no idle interval.
- R9: During reset and whenever no frame is in progress, `tx_line` is high and `busy` is low. When a frame ends with no word pending, the line returns to high and `busy` drops.
- R10: A change of `cfg_len`, `cfg_parity`, `cfg_two_stop` or `in_data` after acceptance does not alter the frame in progress.
- R11: `busy` is high from the cycle after acceptance until the last stop bit has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per bit interval |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The word is taken at this edge if valid |
| in_data | input | DATA_MAX (9) | Character, LSB first on the line |
| cfg_len | input | $clog2(DATA_MAX+1) (4) | Character length, clamped to 5..9 |
| cfg_parity | input | 2 | Parity mode (see R4) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame is being sent |

## Verification
`in_ready` is combinational in the same cycle as `tick`. The start bit appears one clock edge after the accepting edge, and every later bit, including a back-to-back start bit, appears exactly one tick interval after the one before. The bench produces ticks on a fixed four-cycle grid. It counts falling edges from the accepting edge and samples each bit on the first falling edge inside its interval, one cycle after the register that drives the line has loaded or shifted. It checks `in_ready` on the last falling edge of each interval, where `tick` is high. It checks the idle level on the first falling edge after the final stop interval.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSV  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_mode_e;
endpackage

// File: rtl/txf_framer.sv
module txf_framer #(
  parameter int DMAX = 9,
  parameter int DMIN = 5,
  parameter int LW   = $clog2(DMAX + 1),
  parameter int FW   = DMAX + 4,
  parameter int CW   = $clog2(FW + 1)
) (
  input  logic [DMAX-1:0] data,
  input  logic [LW-1:0]   len_cfg,
  input  logic [1:0]      mode,
  input  logic            two_stop,
  output logic [FW-1:0]   frame,
  output logic [CW-1:0]   nbits
);
  import txf_pkg::*;

  function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] l);
    if (l < LW'(DMIN)) return LW'(DMIN);
    if (l > LW'(DMAX)) return LW'(DMAX);
    return l;
  endfunction

  function automatic logic fold_parity(input logic [DMAX-1:0] d,
                                       input logic [LW-1:0] l,
                                       input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(l)) p = p ^ d[i];
    return p;
  endfunction

  par_mode_e    pm;
  logic         par_en;
  logic         par_bit;
  logic [LW-1:0] len_c;

  always_comb begin
    pm      = par_mode_e'(mode);
    par_en  = (pm == PAR_EVEN) || (pm == PAR_ODD);
    len_c   = clamp_len(len_cfg);
    par_bit = fold_parity(data, len_c, pm == PAR_ODD);
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(len_c)) frame[i+1] = data[i];
    for (int i = DMIN; i <= DMAX; i++)
      if (par_en && i == int'(len_c)) frame[i+1] = par_bit;
    nbits = CW'(2) + CW'(len_c) + CW'(par_en) + CW'(two_stop);
  end
endmodule

// File: rtl/txf_shifter.sv
module txf_shifter #(
  parameter int FW = 13,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] nbits_in,
  output logic          line,
  output logic          busy,
  output logic          last
);
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (tick) begin
      if (load) begin
        sh_q  <= frame_in;
        cnt_q <= nbits_in;
      end else if (cnt_q != '0) begin
        sh_q  <= {1'b1, sh_q[FW-1:1]};
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));
  assign line = busy ? sh_q[0] : 1'b1;

  p_load_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (nbits_in >= CW'(7) && nbits_in <= CW'(FW)));
  p_hold_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(line));
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
endmodule

// File: rtl/txf_serial_tx.sv
module txf_serial_tx #(
  parameter  int DATA_MAX = 9,
  parameter  int DATA_MIN = 5,
  localparam int LEN_W    = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  output logic                tx_line,
  output logic                busy
);
  localparam int FRAME_W = DATA_MAX + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   nbits_w;
  logic               last_bit;
  logic               accept;
  logic               frame_done;

  txf_framer #(.DMAX(DATA_MAX), .DMIN(DATA_MIN), .LW(LEN_W),
               .FW(FRAME_W), .CW(CNT_W)) u_framer (
    .data(in_data), .len_cfg(cfg_len), .mode(cfg_parity),
    .two_stop(cfg_two_stop), .frame(frame_w), .nbits(nbits_w)
  );

  txf_shifter #(.FW(FRAME_W), .CW(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(accept),
    .frame_in(frame_w), .nbits_in(nbits_w),
    .line(tx_line), .busy(busy), .last(last_bit)
  );

  assign in_ready   = tick && (!busy || last_bit);
  assign accept     = in_valid && in_ready;
  assign frame_done = tick && last_bit;

  p_ready_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tick);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!tx_line && busy));
  p_b2b_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && in_valid) |=> !tx_line);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !in_valid) |=> (tx_line && !busy));
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_bit) |=> busy);
endmodule

// File: tb/sim_txf_serial_tx.sv
module sim_txf_serial_tx;
  localparam int TD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_two_stop = 1'b0;
  logic       tx_line;
  logic       busy;

  int checks = 0;
  int failures = 0;
  int div = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tick <= (div == TD - 1);
    div  <= (div == TD - 1) ? 0 : div + 1;
  end

  txf_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .tx_line(tx_line), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_len(input logic [3:0] l);
    if (l < 5) return 5;
    if (l > 9) return 9;
    return int'(l);
  endfunction

  // expected line value of bit k; tag names the requirement it belongs to
  function automatic bit exp_bit(input logic [8:0] d, input int L, input logic [1:0] pm,
                                 input int k, output string tag);
    int ones;
    if (k == 0) begin tag = "R1 start"; return 1'b0; end
    if (k <= L) begin tag = "R2 data"; return d[k-1]; end
    if (k == L + 1 && pm[1]) begin
      ones = 0;
      for (int i = 0; i < L; i++) ones += int'(d[i]);
      tag = "R5 parity";
      return ((ones % 2) == 1) ^ pm[0];
    end
    tag = "R6 stop";
    return 1'b1;
  endfunction

  task automatic run(input logic [8:0] d0, input logic [8:0] d1,
                     input bit pair, input bit scramble);
    int L, nb, nfr;
    logic [1:0] pm;
    logic [3:0] sv_len;
    logic [1:0] sv_par;
    logic sv_two;
    logic [8:0] dd;
    string tag;
    bit e;
    L  = eff_len(cfg_len);
    pm = cfg_parity;
    nb = 1 + L + (pm[1] ? 1 : 0) + 1 + (cfg_two_stop ? 1 : 0);
    sv_len = cfg_len; sv_par = cfg_parity; sv_two = cfg_two_stop;
    nfr = pair ? 2 : 1;
    in_data  = d0;
    in_valid = 1'b1;
    do begin @(negedge clk); #1; end while (!in_ready);
    @(posedge clk);
    for (int f = 0; f < nfr; f++) begin
      dd = (f == 0) ? d0 : d1;
      for (int k = 0; k < nb; k++) begin
        @(negedge clk); #1;
        if (k == 0) begin
          if (f == 0 && pair) in_data = d1;
          else begin in_valid = 1'b0; in_data = ~in_data; end
        end
        e = exp_bit(dd, L, pm, k, tag);
        chk(tx_line == e, tag, tx_line, e);
        chk(busy == 1'b1, "R11 busy", busy, 1);
        if (scramble && k == 0) begin
          cfg_len = 4'd15 - cfg_len; cfg_parity = ~cfg_parity; cfg_two_stop = ~cfg_two_stop;
        end
        repeat (TD - 1) @(negedge clk);
        #1;
        if (k != nb - 1) chk(in_ready == 1'b0, "R1 ready mid-frame", in_ready, 0);
      end
    end
    @(negedge clk); #1;
    chk(tx_line == 1'b1, "R9 idle line", tx_line, 1);
    chk(busy == 1'b0, "R9 idle busy", busy, 0);
    cfg_len = sv_len; cfg_parity = sv_par; cfg_two_stop = sv_two;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk(tx_line == 1'b1, "R9 reset line", tx_line, 1);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    chk(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // sweep every length (including clamped ones, R3), parity mode (R4) and stop count
    for (int l = 3; l <= 11; l++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++) begin
          cfg_len = 4'(l); cfg_parity = 2'(p); cfg_two_stop = 1'(s);
          run(9'h1A5 ^ 9'(l * 37 + p * 11 + s), 9'h000, 1'b0, 1'b0);
          run(9'h0F3 + 9'(l * 5 + p), 9'h000, 1'b0, 1'b0);
        end
    // R3 clamp extremes
    cfg_len = 4'd0;  cfg_parity = 2'b10; cfg_two_stop = 1'b0; run(9'h1FF, 9'h0, 1'b0, 1'b0);
    cfg_len = 4'd15; cfg_parity = 2'b11; cfg_two_stop = 1'b1; run(9'h155, 9'h0, 1'b0, 1'b0);
    // R5 inactive upper bits ignored
    cfg_len = 4'd5; cfg_parity = 2'b10; cfg_two_stop = 1'b0; run(9'h1E0, 9'h0, 1'b0, 1'b0);
    // R10 configuration and data changed mid-frame
    for (int p = 0; p < 4; p++) begin
      cfg_len = 4'd7; cfg_parity = 2'(p); cfg_two_stop = 1'(p & 1);
      run(9'h0B6 + 9'(p), 9'h0, 1'b0, 1'b1);
    end
    // R8 back-to-back frames
    cfg_len = 4'd8; cfg_parity = 2'b11; cfg_two_stop = 1'b0; run(9'h0C3, 9'h03C, 1'b1, 1'b0);
    cfg_len = 4'd9; cfg_parity = 2'b00; cfg_two_stop = 1'b1; run(9'h1FF, 9'h100, 1'b1, 1'b0);
    cfg_len = 4'd5; cfg_parity = 2'b01; cfg_two_stop = 1'b0; run(9'h015, 9'h00A, 1'b1, 1'b0);
    // R7: line holds steady across a whole idle tick interval
    repeat (8) begin
      @(negedge clk); #1;
      chk(tx_line == 1'b1, "R7 idle hold", tx_line, 1);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule